// File: doc/BRIEF.md
# Quarter-Period IF Sampling I/Q Demodulator

This block turns a stream of signed ADC samples of an intermediate-frequency (IF) carrier into in-phase (I) and quadrature (Q) words. The sample clock is locked to exactly four times the IF, with both derived from one common reference, so every IF period holds four samples at fixed quarter-period points. In each period these samples are Q, I, −Q and −I in that order. No mixer or oscillator table is needed. A 2-bit phase index labels each valid sample. The third and fourth samples of a period are negated, and each pair of samples yields one I/Q estimate.

The estimates can be published as they arrive, twice per IF period. They can also be averaged over a block of 2^K IF periods to reduce noise, with the mean taken by an arithmetic shift. Each published pair is raised with a one-cycle strobe. The block also drives an offset-binary copy of each word, ready for a pair of DACs that feed an analog vector modulator. A sync input aligns the phase index to the Q sample and restarts averaging.

Top module: `quadIfDemod`

## Requirements
- R1: While in reset and after it, iOut and qOut are 0, iqStrobe is low, and iDac and qDac are 16'h8000.
- R2: Only cycles with sampleValid high advance the phase index (0,1,2,3,0,...). On other cycles, sampleIn and syncIn have no effect on any output.
- R3: A valid sample presented with syncIn high takes phase index 0. Any partly filled averaging block is discarded, and the averaging exponent is loaded from avgLog2.
- R4: With exponent 0, the sample at index 1 publishes I = sample(1) and Q = sample(0). The sample at index 3 publishes I = −sample(3) and Q = −sample(2). New values and the strobe appear in the cycle after the clock edge that takes that sample.
- R5: Negating the most negative 14-bit code (−8192) gives +8191.
- R6: With exponent K from 1 to 6, one pair is published per 2^K IF periods, on the index-3 sample that closes the block. Each word is the sum of its 2^(K+1) estimates, arithmetically shifted right by K+1, which rounds toward minus infinity.
- R7: avgLog2 values above 6 are treated as 6.
- R8: A change of avgLog2 takes effect only at a sync sample or at the end of a block.
- R9: iOut and qOut hold their values in every cycle in which iqStrobe is low. iqStrobe is never high for two cycles in a row.
- R10: iOut and qOut are 16-bit two's complement, sign-extended from 14 significant bits.
- R11: iDac and qDac equal iOut and qOut with bit 15 inverted (offset binary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the IF |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | sampleIn carries an ADC sample this cycle |
| sampleIn | input | 14 | Signed ADC sample |
| syncIn | input | 1 | Marks the current valid sample as the Q sample (index 0) |
| avgLog2 | input | 3 | Averaging exponent K; 0 means no averaging |
| iOut | output | 16 | Signed I word |
| qOut | output | 16 | Signed Q word |
| iqStrobe | output | 1 | One-cycle pulse with each new I/Q pair |
| iDac | output | 16 | I in offset binary |
| qDac | output | 16 | Q in offset binary |

## Verification
Every I/Q pair is due exactly one cycle after the rising edge that takes its closing sample (index 1 or 3 with no averaging, or the block's last index-3 sample). The DAC words follow in the same cycle as the signed words. The driver updates its reference model and queues the expected pair before that edge. The monitor samples on the falling edge that follows, so each strobe is compared against the head of the queue. A strobe with an empty queue is a failure, and so is a pair still queued at the end. In every strobe-free cycle the monitor also confirms that the words have not moved.

// File: rtl/quadIfPkg.sv
package quadIfPkg;

  // Per-sample strobes from control to datapath.
  typedef struct packed {
    logic takeQ;   // sample is a Q-position sample (index 0 or 2)
    logic takeI;   // sample is an I-position sample (index 1 or 3)
    logic negate;  // sample belongs to the second half of the period
    logic first;   // estimate opens an averaging block
    logic last;    // estimate closes an averaging block
  } qifCtrlT;

endpackage

// File: rtl/quadIfCtrl.sv
module quadIfCtrl
  import quadIfPkg::*;
#(
  parameter int MAX_LOG2 = 6,
  parameter int K_W      = $clog2(MAX_LOG2 + 1),
  parameter int SHIFT_W  = K_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               syncIn,
  input  logic [K_W-1:0]     avgLog2,
  output qifCtrlT            ctrl,
  output logic [SHIFT_W-1:0] shiftAmt
);

  localparam int CNT_W = MAX_LOG2 + 1;

  logic [1:0]       phaseQ;
  logic [1:0]       idx;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [K_W-1:0]   kActive;
  logic [K_W-1:0]   kClamped;
  logic [CNT_W:0]   blockLen;

  assign kClamped = (avgLog2 > K_W'(MAX_LOG2)) ? K_W'(MAX_LOG2) : avgLog2;
  assign idx      = syncIn ? 2'd0 : phaseQ;

  // Averaging block: one estimate without averaging, else 2^(K+1) estimates.
  always_comb begin
    if (kActive == '0) begin
      shiftAmt = '0;
      blockLen = (CNT_W + 1)'(1);
    end else begin
      shiftAmt = SHIFT_W'(kActive) + SHIFT_W'(1);
      blockLen = (CNT_W + 1)'(1) << shiftAmt;
    end
    lastIdx = CNT_W'(blockLen - (CNT_W + 1)'(1));
  end

  always_comb begin
    ctrl.takeQ  = sampleValid && !idx[0];
    ctrl.takeI  = sampleValid && idx[0];
    ctrl.negate = idx[1];
    ctrl.first  = (halfCnt == '0);
    ctrl.last   = (halfCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= '0;
      halfCnt <= '0;
      kActive <= '0;
    end else if (sampleValid) begin
      phaseQ <= idx + 2'd1;
      if (syncIn) begin
        halfCnt <= '0;
        kActive <= kClamped;
      end else if (ctrl.takeI) begin
        if (ctrl.last) begin
          halfCnt <= '0;
          kActive <= kClamped;
        end else begin
          halfCnt <= halfCnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: the phase index steps by one on each valid sample without sync
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !syncIn) |=> (phaseQ == $past(phaseQ) + 2'd1));

  // R2: cycles without a valid sample leave the index where it was
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(phaseQ));

  // R7: the active exponent never exceeds the largest supported value
  assert_k_clamp_R7: assert property (@(posedge clk) disable iff (!rstN)
    kActive <= K_W'(MAX_LOG2));

  // R6: the estimate count stays inside the current block
  assert_block_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt <= lastIdx);

  // R8: the exponent only moves on a sync sample or at a block end
  assert_k_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && (syncIn || (ctrl.takeI && ctrl.last))) |=> $stable(kActive));

endmodule

// File: rtl/quadIfChanAvg.sv
module quadIfChanAvg #(
  parameter int SAMPLE_W = 14,
  parameter int OUT_W    = 16,
  parameter int MAX_LOG2 = 6,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       take,
  input  logic                       first,
  input  logic                       last,
  input  logic [SHIFT_W-1:0]         shiftAmt,
  input  logic signed [SAMPLE_W-1:0] est,
  output logic signed [OUT_W-1:0]    outWord
);

  localparam int ACC_W = SAMPLE_W + MAX_LOG2 + 1;

  logic signed [ACC_W-1:0] accQ;
  logic signed [ACC_W-1:0] accNext;
  logic signed [ACC_W-1:0] meanVal;

  assign accNext = (first ? ACC_W'(0) : accQ) + ACC_W'(est);
  assign meanVal = accNext >>> shiftAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      outWord <= '0;
    end else if (take) begin
      if (last) begin
        outWord <= OUT_W'(meanVal);
        accQ    <= '0;
      end else begin
        accQ <= accNext;
      end
    end
  end

  // R10: the word carries a sign extension above its significant bits
  assert_sign_ext_R10: assert property (@(posedge clk) disable iff (!rstN)
    (&outWord[OUT_W-1:SAMPLE_W-1]) || !(|outWord[OUT_W-1:SAMPLE_W-1]));

  // R9: the word moves only when a block is closed
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(take && last) |=> $stable(outWord));

endmodule

// File: rtl/quadIfDatapath.sv
module quadIfDatapath
  import quadIfPkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int OUT_W    = 16,
  parameter int MAX_LOG2 = 6,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  qifCtrlT                    ctrl,
  input  logic [SHIFT_W-1:0]         shiftAmt,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [OUT_W-1:0]    iOut,
  output logic signed [OUT_W-1:0]    qOut,
  output logic [OUT_W-1:0]           iDac,
  output logic [OUT_W-1:0]           qDac,
  output logic                       iqStrobe
);

  localparam int NUM_CH = 2;  // channel 0 = I, channel 1 = Q
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic signed [SAMPLE_W-1:0] negated;
  logic signed [SAMPLE_W-1:0] est;
  logic signed [SAMPLE_W-1:0] pendQ;
  logic signed [SAMPLE_W-1:0] chanEst [NUM_CH];
  logic signed [OUT_W-1:0]    chanOut [NUM_CH];
  logic [OUT_W-1:0]           chanDac [NUM_CH];

  // Saturating two's complement negation.
  assign negated = (sampleIn == MOST_NEG) ? MOST_POS : -sampleIn;
  assign est     = ctrl.negate ? negated : sampleIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      iqStrobe <= 1'b0;
    end else begin
      if (ctrl.takeQ) pendQ <= est;
      iqStrobe <= ctrl.takeI && ctrl.last;
    end
  end

  assign chanEst[0] = est;
  assign chanEst[1] = pendQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    quadIfChanAvg #(
      .SAMPLE_W(SAMPLE_W),
      .OUT_W   (OUT_W),
      .MAX_LOG2(MAX_LOG2),
      .SHIFT_W (SHIFT_W)
    ) avg_i (
      .clk     (clk),
      .rstN    (rstN),
      .take    (ctrl.takeI),
      .first   (ctrl.first),
      .last    (ctrl.last),
      .shiftAmt(shiftAmt),
      .est     (chanEst[ch]),
      .outWord (chanOut[ch])
    );
    assign chanDac[ch] = {~chanOut[ch][OUT_W-1], chanOut[ch][OUT_W-2:0]};
  end

  assign iOut = chanOut[0];
  assign qOut = chanOut[1];
  assign iDac = chanDac[0];
  assign qDac = chanDac[1];

  // R9: a strobe is a single-cycle pulse
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    iqStrobe |=> !iqStrobe);

  // R5: a negated estimate is never the most negative code
  assert_neg_sat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.takeQ && ctrl.negate) |=> (pendQ != MOST_NEG));

endmodule

// File: rtl/quadIfDemod.sv
module quadIfDemod
  import quadIfPkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int OUT_W    = 16,
  parameter int MAX_LOG2 = 6,
  parameter int K_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       syncIn,
  input  logic [K_W-1:0]             avgLog2,
  output logic signed [OUT_W-1:0]    iOut,
  output logic signed [OUT_W-1:0]    qOut,
  output logic                       iqStrobe,
  output logic [OUT_W-1:0]           iDac,
  output logic [OUT_W-1:0]           qDac
);

  localparam int SHIFT_W = K_W + 1;

  qifCtrlT            ctrl;
  logic [SHIFT_W-1:0] shiftAmt;

  quadIfCtrl #(
    .MAX_LOG2(MAX_LOG2),
    .K_W     (K_W),
    .SHIFT_W (SHIFT_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .syncIn     (syncIn),
    .avgLog2    (avgLog2),
    .ctrl       (ctrl),
    .shiftAmt   (shiftAmt)
  );

  quadIfDatapath #(
    .SAMPLE_W(SAMPLE_W),
    .OUT_W   (OUT_W),
    .MAX_LOG2(MAX_LOG2),
    .SHIFT_W (SHIFT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .shiftAmt(shiftAmt),
    .sampleIn(sampleIn),
    .iOut    (iOut),
    .qOut    (qOut),
    .iDac    (iDac),
    .qDac    (qDac),
    .iqStrobe(iqStrobe)
  );

  // R11: the offset-binary words differ from the signed ones only in the MSB
  assert_dac_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (iDac[OUT_W-2:0] == iOut[OUT_W-2:0]) && (qDac[OUT_W-2:0] == qOut[OUT_W-2:0]));

endmodule

// File: tb/quadIfDemod_tb_top.sv
module quadIfDemod_tb_top;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [13:0] sampleIn = '0;
  logic               syncIn = 1'b0;
  logic [2:0]         avgLog2 = '0;
  logic signed [15:0] iOut, qOut;
  logic               iqStrobe;
  logic [15:0]        iDac, qDac;

  always #2ns clk = ~clk;  // 250 MHz

  quadIfDemod dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .syncIn(syncIn), .avgLog2(avgLog2), .iOut(iOut), .qOut(qOut),
    .iqStrobe(iqStrobe), .iDac(iDac), .qDac(qDac)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int expI[$];
  int expQ[$];

  // Reference model state
  int mPhase = 0, mHalf = 0, mK = 0, mPendQ = 0, mSumI = 0, mSumQ = 0;

  function automatic int clampK(input int k);
    return (k > 6) ? 6 : k;
  endfunction

  function automatic int negSat(input int v);
    return (v == -8192) ? 8191 : -v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one valid sample per call, model updated before the capturing edge.
  task automatic sendSample(input int v, input bit doSync);
    int idx, est, len, sh;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 14'(v);
    syncIn      = doSync;
    if (doSync) begin
      mPhase = 0; mHalf = 0; mK = clampK(int'(avgLog2));
    end
    idx    = mPhase;
    mPhase = (idx + 1) % 4;
    est    = (idx >= 2) ? negSat(v) : v;
    if (idx % 2 == 0) mPendQ = est;
    else begin
      if (mHalf == 0) begin mSumI = 0; mSumQ = 0; end
      mSumI += est;
      mSumQ += mPendQ;
      len = (mK == 0) ? 1 : (1 << (mK + 1));
      sh  = (mK == 0) ? 0 : (mK + 1);
      mHalf++;
      if (mHalf == len) begin
        expI.push_back(mSumI >>> sh);
        expQ.push_back(mSumQ >>> sh);
        mHalf = 0;
        mK = clampK(int'(avgLog2));
      end
    end
  endtask

  // Idle cycles with junk on the data and sync pins (R2: must be ignored).
  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      sampleIn    = 14'($urandom_range(0, 16383));
      syncIn      = $urandom_range(0, 1) != 0;
    end
  endtask

  task automatic sendPeriods(input int n, input bit syncFirst);
    for (int p = 0; p < n; p++)
      for (int s = 0; s < 4; s++) begin
        sendSample($urandom_range(0, 16383) - 8192, syncFirst && p == 0 && s == 0);
        if ($urandom_range(0, 7) == 0) idle(1);
      end
  endtask

  // Monitor: compares each strobe with the queue head; R9 hold check otherwise.
  int lastI = 0, lastQ = 0;
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (finished) break;
      if (iqStrobe) begin
        if (expI.size() == 0) check(1'b0, "R4 unexpected strobe", 1, 0);
        else begin
          int ei, eq;
          ei = expI.pop_front();
          eq = expQ.pop_front();
          check(int'(iOut) == ei, "R4/R6 iOut", int'(iOut), ei);
          check(int'(qOut) == eq, "R4/R6 qOut", int'(qOut), eq);
        end
        lastI = int'(iOut);
        lastQ = int'(qOut);
      end else begin
        check(int'(iOut) == lastI && int'(qOut) == lastQ, "R9 hold", int'(iOut), lastI);
      end
      check(iDac == (16'(iOut) ^ 16'h8000), "R11 iDac", int'(iDac), int'(16'(iOut) ^ 16'h8000));
      check(qDac == (16'(qOut) ^ 16'h8000), "R11 qDac", int'(qDac), int'(16'(qOut) ^ 16'h8000));
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(iOut == 0 && qOut == 0, "R1 words", int'(iOut), 0);
    check(!iqStrobe, "R1 strobe", int'(iqStrobe), 0);
    check(iDac == 16'h8000 && qDac == 16'h8000, "R1 dac", int'(iDac), 32'h8000);
    rstN = 1'b1;
    @(negedge clk);
    check(iOut == 0 && iDac == 16'h8000, "R1 after release", int'(iOut), 0);

    // R4: no averaging, fixed pattern then random; R2 junk in gaps
    avgLog2 = 3'd0;
    sendSample(100, 1'b1); sendSample(-200, 1'b0);
    sendSample(-300, 1'b0); sendSample(400, 1'b0);
    idle(3);
    sendPeriods(6, 1'b0);
    // R5: most negative code in the negated positions
    sendSample(5, 1'b0); sendSample(7, 1'b0);
    sendSample(-8192, 1'b0); sendSample(-8192, 1'b0);
    // R3: sync in mid-period realigns to Q
    sendSample(11, 1'b0);
    sendSample(21, 1'b1); sendSample(-22, 1'b0);
    sendSample(23, 1'b0); sendSample(-24, 1'b0);
    idle(4);

    // R6: K=2 and K=1 with extreme values (floor of negative sums)
    avgLog2 = 3'd2;
    sendPeriods(8, 1'b1);
    avgLog2 = 3'd1;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++) sendSample((s == 1) ? -8191 : -8192, p == 0 && s == 0);
    sendPeriods(4, 1'b0);

    // R3: partial block discarded by sync
    avgLog2 = 3'd3;
    sendPeriods(3, 1'b1);
    sendPeriods(8, 1'b1);

    // R8: exponent change mid-block applies only at the block end
    avgLog2 = 3'd1;
    sendPeriods(1, 1'b1);
    avgLog2 = 3'd3;
    sendPeriods(1, 1'b0);
    sendPeriods(8, 1'b0);

    // R7: 7 treated as 6 (64 periods per block)
    avgLog2 = 3'd7;
    sendPeriods(128, 1'b1);
    avgLog2 = 3'd0;
    sendPeriods(2, 1'b1);
    idle(6);

    check(expI.size() == 0, "R6 pending pairs", expI.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule